// File: doc/BRIEF.md
# Multi-Issue Register Overlap Splitter

This block sits between instruction decode and the dependency-tracking matrices of a multi-issue core. Each cycle it is offered a group of up to `SLOTS` decoded instructions, oldest in slot 0. Each instruction carries up to two source register numbers and one destination register number, and each of these has its own valid bit. The block finds the longest run of instructions, starting at the oldest, in which no instruction names a register that an older member of the same group also names. It reports that run as an issue count and as a thermometer accept mask.

The group is cut at the first instruction that overlaps an older one. That instruction and everything younger stay with the upstream stage, and the conflicting instruction becomes slot 0 of the next offer. The accepted set therefore never shares a register between two members, so the matrices never see a row or column conflict inside one issue group. The oldest valid instruction is always taken, which guarantees forward progress. A low downstream-ready input withholds the whole group.

The decision is registered. The outputs seen in a cycle describe the group that was presented at the previous rising clock edge.

Top module: `iss_splitter`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next outputs are `issue_cnt` = 0 and `accept_mask` = 0.
- R2: The outputs are registered. After a rising edge they describe the inputs sampled at that edge and do not change until the next edge.
- R3: When `dn_ready` = 1 and slot 0 is valid, slot 0 is always accepted (`issue_cnt` >= 1), even when its own operands name the same register.
- R4: A valid younger slot with any valid operand equal to any valid operand of an older slot ends the group. `issue_cnt` then equals the index of the first such slot. Read-after-write, write-after-read and write-after-write overlaps all count.
- R5: Two sources that name the same register (read-read) also count as an overlap and cut the group.
- R6: An operand whose valid bit is 0 takes part in no comparison, whatever its register number.
- R7: A slot with `slot_vld` = 0 ends the group at its position, even when younger slots are valid.
- R8: When `dn_ready` = 0 at the sampling edge, the next `issue_cnt` is 0 and `accept_mask` is 0.
- R9: `accept_mask` is a thermometer code. Bit k is 1 exactly when k < `issue_cnt`, and `issue_cnt` is a binary value from 0 to `SLOTS`.
- R10: No two accepted slots share any valid register operand.
- R11: When all slots are valid and every valid operand is distinct across slots, all `SLOTS` instructions are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dn_ready | input | 1 | Dependency matrices can take a group this cycle |
| slot_vld | input | SLOTS | Per-slot instruction valid, bit 0 is oldest |
| src0_vld | input | SLOTS | First source operand valid per slot |
| src0_idx | input | SLOTS*REG_W | First source register number, slot k at bits [k*REG_W +: REG_W] |
| src1_vld | input | SLOTS | Second source operand valid per slot |
| src1_idx | input | SLOTS*REG_W | Second source register number, same packing |
| dst_vld | input | SLOTS | Destination operand valid per slot |
| dst_idx | input | SLOTS*REG_W | Destination register number, same packing |
| issue_cnt | output | $clog2(SLOTS+1) | Number of slots accepted, counted from slot 0 |
| accept_mask | output | SLOTS | Thermometer mask of accepted slots |

## Verification
The bound checker watches four properties on every cycle against a registered copy of the inputs: the ready gate, the guaranteed acceptance of slot 0, the thermometer shape of the mask, and the absence of any shared register or invalid slot inside the accepted set. Where exactly the group is cut can only be shown by the bench's vectors, since a design that cuts too early still satisfies every safety property. Those vectors cover each overlap kind, masked operand valid bits, invalid holes, self-overlap in slot 0, the one-cycle latency and reset taken in the middle of a run.

// File: rtl/iss_split_pkg.sv
// Package: shared constants and the operand-role encoding used by the
// overlap splitter. Assumes three operand roles per instruction.
package iss_split_pkg;
    localparam int OPS = 3;

    typedef enum int unsigned {
        OP_SRC0 = 0,
        OP_SRC1 = 1,
        OP_DST  = 2
    } op_role_e;
endpackage

// File: rtl/iss_pair_overlap.sv
// Compares every valid operand of an older slot against every valid
// operand of a younger slot and flags any shared register number.
// Assumes operands with a clear valid bit carry don't-care numbers.
module iss_pair_overlap #(
    parameter int REG_W = 5,
    parameter int OPS   = 3
) (
    input  logic [OPS-1:0]            old_vld,
    input  logic [OPS-1:0][REG_W-1:0] old_idx,
    input  logic [OPS-1:0]            yng_vld,
    input  logic [OPS-1:0][REG_W-1:0] yng_idx,
    output logic                      hit
);
    // Full cross-compare of the two operand sets.
    always_comb begin
        hit = 1'b0;
        for (int a = 0; a < OPS; a++) begin
            for (int b = 0; b < OPS; b++) begin
                if (old_vld[a] && yng_vld[b] && (old_idx[a] == yng_idx[b]))
                    hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iss_cut_locate.sv
// Walks the per-slot blocked flags from the oldest slot and stops at the
// first blocked one; produces the binary count and thermometer mask.
// Assumes blocked[0] is only set for an invalid slot 0.
module iss_cut_locate #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3
) (
    input  logic             go,
    input  logic [SLOTS-1:0] blocked,
    output logic [CNT_W-1:0] cnt,
    output logic [SLOTS-1:0] mask
);
    // Running AND from slot 0 upward, counting surviving slots.
    always_comb begin
        logic run;
        run  = go;
        cnt  = '0;
        mask = '0;
        for (int k = 0; k < SLOTS; k++) begin
            run     = run & ~blocked[k];
            mask[k] = run;
            if (run) cnt = cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/iss_out_stage.sv
// Output register for the issue decision, cleared by synchronous
// active-low reset. Assumes the next values are settled before the edge.
module iss_out_stage #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [SLOTS-1:0] mask_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [SLOTS-1:0] mask_q
);
    // Capture the decision, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mask_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/iss_splitter.sv
// Top: decides how many of the offered instructions, counted from the
// oldest, may issue together with no register shared inside the group.
// Assumes slot 0 is the oldest and that upstream re-offers the rest.
module iss_splitter
    import iss_split_pkg::*;
#(
    parameter  int SLOTS = 4,
    parameter  int REG_W = 5,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dn_ready,
    input  logic [SLOTS-1:0]       slot_vld,
    input  logic [SLOTS-1:0]       src0_vld,
    input  logic [SLOTS*REG_W-1:0] src0_idx,
    input  logic [SLOTS-1:0]       src1_vld,
    input  logic [SLOTS*REG_W-1:0] src1_idx,
    input  logic [SLOTS-1:0]       dst_vld,
    input  logic [SLOTS*REG_W-1:0] dst_idx,
    output logic [CNT_W-1:0]       issue_cnt,
    output logic [SLOTS-1:0]       accept_mask
);
    logic [SLOTS-1:0][OPS-1:0]            opv;
    logic [SLOTS-1:0][OPS-1:0][REG_W-1:0] opi;
    logic [SLOTS-1:0][SLOTS-1:0]          conf;
    logic [SLOTS-1:0]                     blocked;
    logic [CNT_W-1:0]                     cnt_d;
    logic [SLOTS-1:0]                     mask_d;

    // Gather each slot's operands into role-indexed arrays.
    for (genvar s = 0; s < SLOTS; s++) begin : g_gather
        assign opv[s][OP_SRC0] = src0_vld[s];
        assign opv[s][OP_SRC1] = src1_vld[s];
        assign opv[s][OP_DST]  = dst_vld[s];
        assign opi[s][OP_SRC0] = src0_idx[s*REG_W +: REG_W];
        assign opi[s][OP_SRC1] = src1_idx[s*REG_W +: REG_W];
        assign opi[s][OP_DST]  = dst_idx[s*REG_W +: REG_W];
    end

    // One comparator block for each older/younger slot pair.
    for (genvar j = 0; j < SLOTS; j++) begin : g_yng
        for (genvar i = 0; i < SLOTS; i++) begin : g_old
            if (i < j) begin : g_cmp
                iss_pair_overlap #(.REG_W(REG_W), .OPS(OPS)) u_cmp (
                    .old_vld (opv[i]),
                    .old_idx (opi[i]),
                    .yng_vld (opv[j]),
                    .yng_idx (opi[j]),
                    .hit     (conf[j][i])
                );
            end else begin : g_none
                assign conf[j][i] = 1'b0;
            end
        end
        assign blocked[j] = ~slot_vld[j] | (|conf[j]);
    end

    iss_cut_locate #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cut (
        .go      (dn_ready),
        .blocked (blocked),
        .cnt     (cnt_d),
        .mask    (mask_d)
    );

    iss_out_stage #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_d  (cnt_d),
        .mask_d (mask_d),
        .cnt_q  (issue_cnt),
        .mask_q (accept_mask)
    );
endmodule

// File: rtl/iss_split_chk.sv
// Checker bound to the splitter: keeps a registered copy of the offered
// group and checks the decision against it on every cycle.
// Assumes the one-cycle output latency of the top module.
module iss_split_chk #(
    parameter  int SLOTS = 4,
    parameter  int REG_W = 5,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dn_ready,
    input logic [SLOTS-1:0]       slot_vld,
    input logic [SLOTS-1:0]       src0_vld,
    input logic [SLOTS*REG_W-1:0] src0_idx,
    input logic [SLOTS-1:0]       src1_vld,
    input logic [SLOTS*REG_W-1:0] src1_idx,
    input logic [SLOTS-1:0]       dst_vld,
    input logic [SLOTS*REG_W-1:0] dst_idx,
    input logic [CNT_W-1:0]       issue_cnt,
    input logic [SLOTS-1:0]       accept_mask
);
    logic                   cap_ok, cap_rdy;
    logic [SLOTS-1:0]       cap_vld;
    logic [3*SLOTS-1:0]     cap_ov;
    logic [3*SLOTS*REG_W-1:0] cap_oi;
    logic                   share;

    // Snapshot the inputs that the registered outputs will describe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ok  <= 1'b0;
            cap_rdy <= 1'b0;
            cap_vld <= '0;
            cap_ov  <= '0;
            cap_oi  <= '0;
        end else begin
            cap_ok  <= 1'b1;
            cap_rdy <= dn_ready;
            cap_vld <= slot_vld;
            cap_ov  <= {dst_vld, src1_vld, src0_vld};
            cap_oi  <= {dst_idx, src1_idx, src0_idx};
        end
    end

    // Search the accepted set for any register named by two members.
    always_comb begin
        share = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            for (int j = i + 1; j < SLOTS; j++)
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 3; b++)
                        if (accept_mask[i] && accept_mask[j] &&
                            cap_ov[a*SLOTS + i] && cap_ov[b*SLOTS + j] &&
                            (cap_oi[(a*SLOTS + i)*REG_W +: REG_W] ==
                             cap_oi[(b*SLOTS + j)*REG_W +: REG_W]))
                            share = 1'b1;
    end

    p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && !cap_rdy) |-> (issue_cnt == '0 && accept_mask == '0));

    p_oldest_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && cap_rdy && cap_vld[0]) |-> (issue_cnt != '0 && accept_mask[0]));

    p_thermo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok |-> (($countones(accept_mask) == int'(issue_cnt)) &&
                    ((accept_mask & (accept_mask + SLOTS'(1))) == '0)));

    p_no_share_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok |-> !share);

    p_hole_cuts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok |-> ((accept_mask & ~cap_vld) == '0));
endmodule

bind iss_splitter iss_split_chk #(.SLOTS(SLOTS), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dn_ready    (dn_ready),
    .slot_vld    (slot_vld),
    .src0_vld    (src0_vld),
    .src0_idx    (src0_idx),
    .src1_vld    (src1_vld),
    .src1_idx    (src1_idx),
    .dst_vld     (dst_vld),
    .dst_idx     (dst_idx),
    .issue_cnt   (issue_cnt),
    .accept_mask (accept_mask)
);

// File: tb/tb_iss_splitter.sv
// Bench: table of offered groups with expected count, then directed
// checks for reset, latency and a reset taken mid-run.
module tb_iss_splitter;
    localparam int  SLOTS    = 4;
    localparam int  REG_W    = 5;
    localparam int  CNT_W    = 3;
    localparam time CLK_PER  = 10;
    localparam int  NV       = 13;

    typedef struct packed {
        logic             v;
        logic             av;
        logic [REG_W-1:0] a;
        logic             bv;
        logic [REG_W-1:0] b;
        logic             dv;
        logic [REG_W-1:0] d;
    } slot_t;

    typedef struct packed {
        logic              rdy;
        slot_t [SLOTS-1:0] sl;
        logic [CNT_W-1:0]  exp;
        logic [3:0]        rq;
    } vec_t;

    // Independent slot k: sources 10+3k, 11+3k, destination 12+3k.
    function automatic slot_t ind(int k);
        slot_t s;
        s.v = 1'b1; s.av = 1'b1; s.bv = 1'b1; s.dv = 1'b1;
        s.a = REG_W'(10 + 3*k);
        s.b = REG_W'(11 + 3*k);
        s.d = REG_W'(12 + 3*k);
        return s;
    endfunction

    function automatic vec_t mk(int n);
        vec_t v;
        v.rdy = 1'b1;
        for (int k = 0; k < SLOTS; k++) v.sl[k] = ind(k);
        v.exp = 3'd4;
        v.rq  = 4'd11;
        case (n)
            0:  ; // R11 all independent
            1:  begin v.sl[2].a = 5'd12; v.exp = 3'd2; v.rq = 4'd4; end  // R4 RAW
            2:  begin v.sl[1].b = 5'd10; v.exp = 3'd1; v.rq = 4'd5; end  // R5 read-read
            3:  begin v.sl[3].d = 5'd14; v.exp = 3'd3; v.rq = 4'd4; end  // R4 WAR
            4:  begin v.sl[2].a = 5'd12; v.sl[2].av = 1'b0; v.rq = 4'd6; end // R6
            5:  begin v.sl[1].d = 5'd12; v.sl[0].dv = 1'b0; v.rq = 4'd6; end // R6
            6:  begin v.sl[2].v = 1'b0; v.exp = 3'd2; v.rq = 4'd7; end   // R7 hole
            7:  begin v.sl[0].v = 1'b0; v.exp = 3'd0; v.rq = 4'd7; end   // R7 slot 0
            8:  begin v.rdy = 1'b0; v.exp = 3'd0; v.rq = 4'd8; end       // R8
            9:  begin v.sl[0].a = 5'd5; v.sl[0].b = 5'd5; v.sl[0].d = 5'd5; v.rq = 4'd3; end // R3 self
            10: begin v.sl[1].d = 5'd12; v.exp = 3'd1; v.rq = 4'd3; end  // R3 WAW at slot 1
            11: begin v.sl[3].a = 5'd16; v.exp = 3'd3; v.rq = 4'd4; end  // R4 adjacent
            12: begin v.sl[3].v = 1'b0; v.exp = 3'd3; v.rq = 4'd7; end   // R7 last slot
            default: ;
        endcase
        return v;
    endfunction

    localparam vec_t TBL [NV] = '{mk(0), mk(1), mk(2), mk(3), mk(4), mk(5),
        mk(6), mk(7), mk(8), mk(9), mk(10), mk(11), mk(12)};

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   dn_ready = 1'b0;
    logic [SLOTS-1:0]       slot_vld = '0, src0_vld = '0, src1_vld = '0, dst_vld = '0;
    logic [SLOTS*REG_W-1:0] src0_idx = '0, src1_idx = '0, dst_idx = '0;
    logic [CNT_W-1:0]       issue_cnt;
    logic [SLOTS-1:0]       accept_mask;
    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    iss_splitter #(.SLOTS(SLOTS), .REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .dn_ready(dn_ready), .slot_vld(slot_vld),
        .src0_vld(src0_vld), .src0_idx(src0_idx), .src1_vld(src1_vld),
        .src1_idx(src1_idx), .dst_vld(dst_vld), .dst_idx(dst_idx),
        .issue_cnt(issue_cnt), .accept_mask(accept_mask)
    );

    task automatic drive(vec_t v);
        dn_ready = v.rdy;
        for (int k = 0; k < SLOTS; k++) begin
            slot_vld[k] = v.sl[k].v;
            src0_vld[k] = v.sl[k].av;
            src1_vld[k] = v.sl[k].bv;
            dst_vld[k]  = v.sl[k].dv;
            src0_idx[k*REG_W +: REG_W] = v.sl[k].a;
            src1_idx[k*REG_W +: REG_W] = v.sl[k].b;
            dst_idx[k*REG_W +: REG_W]  = v.sl[k].d;
        end
    endtask

    // Compare count and thermometer mask (R9) against an expected count.
    task automatic expect_out(int exp, string tag);
        logic [SLOTS-1:0] em;
        em = SLOTS'((1 << exp) - 1);
        checks++;
        if (issue_cnt !== CNT_W'(exp)) begin
            errors++;
            $display("FAIL %s count: got %0d expected %0d", tag, issue_cnt, exp);
        end
        checks++;
        if (accept_mask !== em) begin
            errors++;
            $display("FAIL %s/R9 mask: got %b expected %b", tag, accept_mask, em);
        end
    endtask

    initial begin
        int prev;
        // R1: reset state
        repeat (2) @(negedge clk);
        expect_out(0, "R1 reset");
        rst_n = 1'b1;
        prev = 0;
        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive(TBL[n]);
            #1;
            expect_out(prev, "R2 hold");   // outputs wait for the edge
            @(negedge clk);
            expect_out(int'(TBL[n].exp), $sformatf("R%0d vec%0d", TBL[n].rq, n));
            prev = int'(TBL[n].exp);
        end
        // R1: reset taken in the middle of a run
        drive(TBL[0]);
        @(negedge clk);
        expect_out(4, "R11 pre-reset");
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(0, "R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(4, "R1 after release");
        // R8 then R3: ready toggled on an unchanged group
        dn_ready = 1'b0;
        @(negedge clk);
        expect_out(0, "R8 ready low");
        dn_ready = 1'b1;
        @(negedge clk);
        expect_out(4, "R3 ready back");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule